// File: doc/BRIEF.md
# Flash Program/Erase Sequencer

This block is the embedded controller of a small block-erasable nonvolatile memory model. It receives already-decoded write, block-erase, erase-suspend, erase-resume and clear-status requests, together with an address and data. It checks whether the targeted block may be modified. If so, it runs the operation as an automatic sequence against an internal cell array. The array models two cell rules: erase drives cells toward all ones, and programming can only clear bits.

A write is a program-and-verify loop with a bounded number of attempts. A block erase first programs every word of the block to zero. It then applies whole-block erase pulses and verifies the block word by word. Each erase pulse shifts four ones into every word of the block from the low end, so a word at zero needs four pulses to reach 0xFFFF. Results appear in an 8-bit status byte that a host reads, next to a combinational array read port. Analog supply and high-voltage conditions arrive as digital "valid" inputs.

The array has five blocks. One of them is the boot block, and a configuration input puts it at the lowest or the highest block. A width-select input picks 16-bit word access or byte access for array writes and reads. Status is always a single byte.

Top module: `flash_seq_top`

## Requirements
- R1: After reset, status_o reads 0x80 and every array word reads 0xFFFF.
- R2: In word mode (byte_mode_i=0, addr_i is a word index), a permitted write leaves the word equal to its old value ANDed with wdata_i, and the word reads back on rd_data_o.
- R3: In byte mode (byte_mode_i=1, addr_i is a byte address, bit 0 selects the high byte when 1), a write affects only the selected byte of word addr_i>>1. A byte read returns that byte in rd_data_o[7:0], with the upper bits zero.
- R4: A write or erase request while vpp_ok_i=0 sets status bit 3, leaves the array unchanged and leaves the block ready.
- R5: The boot block is block 0 when boot_top_i=0 and block 4 when boot_top_i=1. A write or erase there with vpp_ok_i=1 and both rp_hv_i and wp_high_i low sets status bit 4 (write) or bit 5 (erase) and changes nothing. If either rp_hv_i or wp_high_i is high, the operation runs. Non-boot blocks need only vpp_ok_i.
- R6: A write that never verifies applies exactly PROG_LIMIT program pulses, so the block is busy 2*PROG_LIMIT cycles. It then sets status bit 4 and returns to ready.
- R7: A block erase pre-programs each word of the block once, in one cycle per word, and then erases until every word reads 0xFFFF. Other blocks are untouched. With the defaults, a block is busy for 23 cycles.
- R8: When the erase pulses needed exceed ERASE_LIMIT, status bit 5 is set and the block is left partially erased. With ERASE_LIMIT=3, each word reads 0x0FFF.
- R9: An erase-suspend request during the erase phase makes status read 0xC0 (ready plus suspended, bit 6). A resume request clears bit 6 and completes the erase.
- R10: Error bits 5:3 are sticky through later operations until a clear-status request is accepted while the block is ready. The clear leaves bits 7 and 6 alone.
- R11: While an erase is suspended, write and erase requests are ignored. The status and the array do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| byte_mode_i | input | 1 | 1 selects byte access, 0 selects word access |
| boot_top_i | input | 1 | 1 places the boot block at the highest block |
| vpp_ok_i | input | 1 | Programming supply valid |
| rp_hv_i | input | 1 | Reset pin held at high voltage |
| wp_high_i | input | 1 | Write-protect pin high |
| wr_req_i | input | 1 | Write request pulse |
| er_req_i | input | 1 | Block erase request pulse |
| susp_req_i | input | 1 | Erase suspend request pulse |
| resume_req_i | input | 1 | Erase resume request pulse |
| clr_req_i | input | 1 | Clear status error bits |
| addr_i | input | 7 | Word index or byte address of the request |
| wdata_i | input | 16 | Write data; the low 8 bits are used in byte mode |
| rd_addr_i | input | 7 | Host read address, same format as addr_i |
| rd_data_o | output | 16 | Host read data |
| status_o | output | 8 | Status: 7 ready, 6 suspended, 5 erase fail, 4 write fail, 3 supply error |

## Verification
Writes are tried in three forms. The first is data that only clears bits, which verifies on the first pulse. The second is data that asks for a one over a zero, which never verifies and shows the attempt limit through the busy length. The third is byte-lane writes, which show that the other lane is kept. Protection is tried with both boot placements and each enable pin alone, which separates the boot check from the supply check. Erases run on two instances with different attempt limits. This distinguishes a completed erase from an exhausted one by the 0x0FFF residue, and its busy length proves that pre-programming happens once per word. A suspend placed inside the erase phase, with a write issued while suspended, shows that the saved position is kept and that new requests are rejected.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_PROG, S_PVER, S_PREP, S_ERASE, S_EVER, S_SUSP
  } seq_state_e;

  localparam int ST_READY = 7;
  localparam int ST_SUSP  = 6;
  localparam int ST_EFAIL = 5;
  localparam int ST_WFAIL = 4;
  localparam int ST_VPP   = 3;
endpackage

// File: rtl/flash_prot_check.sv
module flash_prot_check #(
  parameter int NUM_BLK = 5,
  localparam int BLK_W  = $clog2(NUM_BLK)
) (
  input  logic [BLK_W-1:0] blk_i,
  input  logic             boot_top_i,
  input  logic             vpp_ok_i,
  input  logic             rp_hv_i,
  input  logic             wp_high_i,
  output logic             supply_ok_o,
  output logic             unlocked_o
);
  logic [BLK_W-1:0] boot_blk;

  assign boot_blk    = boot_top_i ? BLK_W'(NUM_BLK - 1) : '0;
  assign supply_ok_o = vpp_ok_i;
  assign unlocked_o  = (blk_i != boot_blk) || rp_hv_i || wp_high_i;
endmodule

// File: rtl/flash_cell_array.sv
module flash_cell_array #(
  parameter int NUM_BLK   = 5,
  parameter int BLK_WORDS = 8,
  localparam int WORDS    = NUM_BLK * BLK_WORDS,
  localparam int WIDX_W   = $clog2(WORDS),
  localparam int BLK_W    = $clog2(NUM_BLK)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_en_i,
  input  logic [WIDX_W-1:0] prog_idx_i,
  input  logic [15:0]       prog_val_i,
  input  logic              erase_en_i,
  input  logic [BLK_W-1:0]  erase_blk_i,
  input  logic [WIDX_W-1:0] vrf_idx_i,
  output logic [15:0]       vrf_data_o,
  input  logic [WIDX_W-1:0] host_idx_i,
  output logic [15:0]       host_data_o
);
  logic [15:0] mem [WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= 16'hFFFF;
    end else begin
      if (prog_en_i && (int'(prog_idx_i) < WORDS))
        mem[prog_idx_i] <= mem[prog_idx_i] & prog_val_i;
      if (erase_en_i) begin
        // each pulse shifts four erased cells in from the low end
        for (int i = 0; i < WORDS; i++)
          if ((i / BLK_WORDS) == int'(erase_blk_i))
            mem[i] <= {mem[i][11:0], 4'hF};
      end
    end
  end

  assign vrf_data_o  = (int'(vrf_idx_i)  < WORDS) ? mem[vrf_idx_i]  : 16'hFFFF;
  assign host_data_o = (int'(host_idx_i) < WORDS) ? mem[host_idx_i] : 16'hFFFF;

  assert_prog_only_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_en_i && !erase_en_i && (int'(prog_idx_i) < WORDS)) |=>
      ((mem[$past(prog_idx_i)] & ~$past(mem[prog_idx_i])) == 16'h0));
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int NUM_BLK     = 5,
  parameter int BLK_WORDS   = 8,
  parameter int PROG_LIMIT  = 4,
  parameter int ERASE_LIMIT = 8,
  localparam int WORDS  = NUM_BLK * BLK_WORDS,
  localparam int WIDX_W = $clog2(WORDS),
  localparam int BLK_W  = $clog2(NUM_BLK),
  localparam int PC_W   = $clog2(PROG_LIMIT + 1),
  localparam int EC_W   = $clog2(ERASE_LIMIT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_req_i,
  input  logic              er_req_i,
  input  logic              susp_req_i,
  input  logic              resume_req_i,
  input  logic              clr_req_i,
  input  logic [WIDX_W-1:0] widx_i,
  input  logic [BLK_W-1:0]  blk_i,
  input  logic [15:0]       tgt_i,
  input  logic [15:0]       mask_i,
  input  logic              supply_ok_i,
  input  logic              unlocked_i,
  output logic              prog_en_o,
  output logic [WIDX_W-1:0] prog_idx_o,
  output logic [15:0]       prog_val_o,
  output logic              erase_en_o,
  output logic [BLK_W-1:0]  erase_blk_o,
  output logic [WIDX_W-1:0] vrf_idx_o,
  input  logic [15:0]       vrf_data_i,
  output logic [7:0]        status_o
);
  seq_state_e        state_q;
  logic [WIDX_W-1:0] idx_q, first_idx, last_idx;
  logic [BLK_W-1:0]  blk_q;
  logic [15:0]       tgt_q, mask_q;
  logic [PC_W-1:0]   pcnt_q;
  logic [EC_W-1:0]   ecnt_q;
  logic [2:0]        err_q;  // {erase fail, write fail, supply}
  logic              ready;

  assign first_idx   = WIDX_W'(blk_q) * WIDX_W'(BLK_WORDS);
  assign last_idx    = first_idx + WIDX_W'(BLK_WORDS - 1);
  assign ready       = (state_q == S_IDLE) || (state_q == S_SUSP);
  assign prog_en_o   = (state_q == S_PROG) || (state_q == S_PREP);
  assign prog_idx_o  = idx_q;
  assign prog_val_o  = (state_q == S_PREP) ? 16'h0000 : tgt_q;
  assign erase_en_o  = (state_q == S_ERASE);
  assign erase_blk_o = blk_q;
  assign vrf_idx_o   = idx_q;
  assign status_o    = {ready, state_q == S_SUSP, err_q, 3'b000};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      blk_q   <= '0;
      tgt_q   <= '1;
      mask_q  <= '0;
      pcnt_q  <= '0;
      ecnt_q  <= '0;
      err_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (clr_req_i) err_q <= '0;
          if (wr_req_i || er_req_i) begin
            if (!supply_ok_i) err_q[0] <= 1'b1;
            else if (!unlocked_i) begin
              if (wr_req_i) err_q[1] <= 1'b1;
              else          err_q[2] <= 1'b1;
            end else if (wr_req_i) begin
              idx_q   <= widx_i;
              tgt_q   <= tgt_i;
              mask_q  <= mask_i;
              pcnt_q  <= '0;
              state_q <= S_PROG;
            end else begin
              blk_q   <= blk_i;
              idx_q   <= WIDX_W'(blk_i) * WIDX_W'(BLK_WORDS);
              ecnt_q  <= '0;
              state_q <= S_PREP;
            end
          end
        end
        S_PROG: begin
          pcnt_q  <= pcnt_q + 1'b1;
          state_q <= S_PVER;
        end
        S_PVER: begin
          if (((vrf_data_i ^ tgt_q) & mask_q) == 16'h0) state_q <= S_IDLE;
          else if (pcnt_q == PC_W'(PROG_LIMIT)) begin
            err_q[1] <= 1'b1;
            state_q  <= S_IDLE;
          end else state_q <= S_PROG;
        end
        S_PREP: begin
          if (idx_q == last_idx) begin
            idx_q   <= first_idx;
            state_q <= S_ERASE;
          end else idx_q <= idx_q + 1'b1;
        end
        S_ERASE: begin
          if (susp_req_i) state_q <= S_SUSP;
          else begin
            ecnt_q  <= ecnt_q + 1'b1;
            state_q <= S_EVER;
          end
        end
        S_EVER: begin
          if (susp_req_i) state_q <= S_SUSP;
          else if (vrf_data_i == 16'hFFFF) begin
            if (idx_q == last_idx) state_q <= S_IDLE;
            else idx_q <= idx_q + 1'b1;
          end else if (ecnt_q == EC_W'(ERASE_LIMIT)) begin
            err_q[2] <= 1'b1;
            state_q  <= S_IDLE;
          end else state_q <= S_ERASE;
        end
        S_SUSP: begin
          if (clr_req_i) err_q <= '0;
          if (resume_req_i) state_q <= S_EVER;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assert_prog_limit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_PROG) |-> (pcnt_q < PC_W'(PROG_LIMIT)));

  assert_erase_limit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_ERASE) |-> (ecnt_q < EC_W'(ERASE_LIMIT)));

  assert_sticky_err_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready |=> ((err_q & $past(err_q)) == $past(err_q)));

  assert_susp_from_erase_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[ST_SUSP]) |-> ($past(state_q) == S_ERASE || $past(state_q) == S_EVER));

  assert_susp_holds_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_SUSP && !resume_req_i) |=> (state_q == S_SUSP));
endmodule

// File: rtl/flash_seq_top.sv
module flash_seq_top #(
  parameter int NUM_BLK     = 5,
  parameter int BLK_WORDS   = 8,
  parameter int PROG_LIMIT  = 4,
  parameter int ERASE_LIMIT = 8,
  localparam int WORDS  = NUM_BLK * BLK_WORDS,
  localparam int WIDX_W = $clog2(WORDS),
  localparam int BLK_W  = $clog2(NUM_BLK),
  localparam int ADDR_W = WIDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_mode_i,
  input  logic              boot_top_i,
  input  logic              vpp_ok_i,
  input  logic              rp_hv_i,
  input  logic              wp_high_i,
  input  logic              wr_req_i,
  input  logic              er_req_i,
  input  logic              susp_req_i,
  input  logic              resume_req_i,
  input  logic              clr_req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       wdata_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [15:0]       rd_data_o,
  output logic [7:0]        status_o
);
  logic [WIDX_W-1:0] widx, host_idx, prog_idx, vrf_idx;
  logic [BLK_W-1:0]  blk, erase_blk;
  logic [15:0]       tgt, mask, prog_val, vrf_data, host_data;
  logic              in_range, supply_ok, unlocked, prog_en, erase_en;

  assign widx     = byte_mode_i ? addr_i[ADDR_W-1:1] : addr_i[ADDR_W-2:0];
  assign host_idx = byte_mode_i ? rd_addr_i[ADDR_W-1:1] : rd_addr_i[ADDR_W-2:0];
  assign blk      = BLK_W'(widx / WIDX_W'(BLK_WORDS));
  assign in_range = int'(widx) < WORDS;
  // lane outside the write stays at ones so the AND leaves it alone
  assign mask = !byte_mode_i ? 16'hFFFF : (addr_i[0] ? 16'hFF00 : 16'h00FF);
  assign tgt  = !byte_mode_i ? wdata_i :
                (addr_i[0] ? {wdata_i[7:0], 8'hFF} : {8'hFF, wdata_i[7:0]});
  assign rd_data_o = !byte_mode_i ? host_data :
                     {8'h00, (rd_addr_i[0] ? host_data[15:8] : host_data[7:0])};

  flash_prot_check #(.NUM_BLK(NUM_BLK)) u_prot (
    .blk_i(blk), .boot_top_i(boot_top_i), .vpp_ok_i(vpp_ok_i),
    .rp_hv_i(rp_hv_i), .wp_high_i(wp_high_i),
    .supply_ok_o(supply_ok), .unlocked_o(unlocked)
  );

  flash_seq_ctrl #(
    .NUM_BLK(NUM_BLK), .BLK_WORDS(BLK_WORDS),
    .PROG_LIMIT(PROG_LIMIT), .ERASE_LIMIT(ERASE_LIMIT)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_req_i(wr_req_i && in_range), .er_req_i(er_req_i && in_range),
    .susp_req_i(susp_req_i), .resume_req_i(resume_req_i), .clr_req_i(clr_req_i),
    .widx_i(widx), .blk_i(blk), .tgt_i(tgt), .mask_i(mask),
    .supply_ok_i(supply_ok), .unlocked_i(unlocked),
    .prog_en_o(prog_en), .prog_idx_o(prog_idx), .prog_val_o(prog_val),
    .erase_en_o(erase_en), .erase_blk_o(erase_blk),
    .vrf_idx_o(vrf_idx), .vrf_data_i(vrf_data), .status_o(status_o)
  );

  flash_cell_array #(.NUM_BLK(NUM_BLK), .BLK_WORDS(BLK_WORDS)) u_array (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .prog_en_i(prog_en), .prog_idx_i(prog_idx), .prog_val_i(prog_val),
    .erase_en_i(erase_en), .erase_blk_i(erase_blk),
    .vrf_idx_i(vrf_idx), .vrf_data_o(vrf_data),
    .host_idx_i(host_idx), .host_data_o(host_data)
  );
endmodule

// File: tb/flash_seq_top_bench.sv
module flash_seq_top_bench;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        byte_mode_i = 0, boot_top_i = 0, vpp_ok_i = 1, rp_hv_i = 0, wp_high_i = 0;
  logic        wr_req_i = 0, er_req_i = 0, susp_req_i = 0, resume_req_i = 0, clr_req_i = 0;
  logic [6:0]  addr_i = '0, rd_addr_i = '0;
  logic [15:0] wdata_i = '0, rd_data_o, rd_data_t;
  logic [7:0]  status_o, status_t;
  int          checks = 0, errors = 0, cyc = 0, busy = 0;

  always #10 clk_i = ~clk_i;

  flash_seq_top u_flash_seq_top (
    .clk_i, .rst_ni, .byte_mode_i, .boot_top_i, .vpp_ok_i, .rp_hv_i, .wp_high_i,
    .wr_req_i, .er_req_i, .susp_req_i, .resume_req_i, .clr_req_i,
    .addr_i, .wdata_i, .rd_addr_i, .rd_data_o, .status_o
  );

  flash_seq_top #(.ERASE_LIMIT(3)) u_flash_seq_top_tight (
    .clk_i, .rst_ni, .byte_mode_i, .boot_top_i, .vpp_ok_i, .rp_hv_i, .wp_high_i,
    .wr_req_i, .er_req_i, .susp_req_i, .resume_req_i, .clr_req_i,
    .addr_i, .wdata_i, .rd_addr_i, .rd_data_o(rd_data_t), .status_o(status_t)
  );

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      finish_run();
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [6:0] a, output logic [15:0] d);
    rd_addr_i = a;
    #1 d = rd_data_o;
  endtask

  task automatic pulse_req(input int which);
    @(negedge clk_i);
    case (which)
      0: wr_req_i = 1; 1: er_req_i = 1; 2: susp_req_i = 1;
      3: resume_req_i = 1; default: clr_req_i = 1;
    endcase
    @(negedge clk_i);
    {wr_req_i, er_req_i, susp_req_i, resume_req_i, clr_req_i} = '0;
  endtask

  task automatic wait_ready();
    busy = 0;
    while (!status_o[7] && busy < 1000) begin
      busy++;
      @(negedge clk_i);
    end
  endtask

  task automatic do_write(input logic [6:0] a, input logic [15:0] d);
    addr_i = a; wdata_i = d;
    pulse_req(0);
    wait_ready();
  endtask

  task automatic do_erase(input logic [6:0] a);
    addr_i = a;
    pulse_req(1);
    wait_ready();
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R1 status", {8'h0, status_o}, 16'h0080);
    rd(7'd0, d);  chk("R1 word0", d, 16'hFFFF);
    rd(7'd39, d); chk("R1 word39", d, 16'hFFFF);
  endtask

  task automatic t_word_write();
    logic [15:0] d;
    do_write(7'd10, 16'h1234);
    rd(7'd10, d); chk("R2 write", d, 16'h1234);
    do_write(7'd10, 16'h1230);
    rd(7'd10, d); chk("R2 clear bits", d, 16'h1230);
    chk("R2 status", {8'h0, status_o}, 16'h0080);
  endtask

  task automatic t_byte();
    logic [15:0] d;
    byte_mode_i = 1;
    do_write(7'd25, 16'h00A5);
    rd(7'd25, d); chk("R3 high byte", d, 16'h00A5);
    rd(7'd24, d); chk("R3 low byte kept", d, 16'h00FF);
    byte_mode_i = 0;
    rd(7'd12, d); chk("R3 word view", d, 16'hA5FF);
  endtask

  task automatic t_vpp();
    logic [15:0] d;
    vpp_ok_i = 0;
    do_write(7'd11, 16'h0000);
    vpp_ok_i = 1;
    chk("R4 status", {8'h0, status_o}, 16'h0088);
    rd(7'd11, d); chk("R4 unchanged", d, 16'hFFFF);
    do_write(7'd13, 16'h7777);
    chk("R10 sticky", {8'h0, status_o}, 16'h0088);
    pulse_req(4);
    chk("R10 cleared", {8'h0, status_o}, 16'h0080);
  endtask

  task automatic t_retry();
    logic [15:0] d;
    do_write(7'd10, 16'hFFFF);
    chk("R6 busy cycles", 16'(busy), 16'd8);
    chk("R6 status", {8'h0, status_o}, 16'h0090);
    rd(7'd10, d); chk("R6 unchanged", d, 16'h1230);
    pulse_req(4);
  endtask

  task automatic t_boot();
    logic [15:0] d;
    boot_top_i = 0;
    do_write(7'd3, 16'h0000);
    chk("R5 bottom locked", {8'h0, status_o}, 16'h0090);
    rd(7'd3, d); chk("R5 locked data", d, 16'hFFFF);
    pulse_req(4);
    wp_high_i = 1;
    do_write(7'd3, 16'h5555);
    wp_high_i = 0;
    rd(7'd3, d); chk("R5 wp unlock", d, 16'h5555);
    boot_top_i = 1;
    do_write(7'd3, 16'h0000);
    rd(7'd3, d); chk("R5 block0 free when top", d, 16'h0000);
    do_write(7'd33, 16'h0000);
    chk("R5 top locked", {8'h0, status_o}, 16'h0090);
    pulse_req(4);
    er_req_i = 0;
    do_erase(7'd33);
    chk("R5 erase locked", {8'h0, status_o}, 16'h00A0);
    pulse_req(4);
    rp_hv_i = 1;
    do_write(7'd33, 16'h00F0);
    rp_hv_i = 0;
    rd(7'd33, d); chk("R5 rp unlock", d, 16'h00F0);
    boot_top_i = 0;
  endtask

  task automatic t_erase();
    logic [15:0] d;
    do_erase(7'd8);
    chk("R7 busy cycles", 16'(busy), 16'd23);
    chk("R7 status", {8'h0, status_o}, 16'h0080);
    rd(7'd10, d); chk("R7 word10", d, 16'hFFFF);
    rd(7'd12, d); chk("R7 word12", d, 16'hFFFF);
    rd(7'd3, d);  chk("R7 other block", d, 16'h0000);
    chk("R8 tight status", {8'h0, status_t}, 16'h00A0);
    rd(7'd8, d); d = rd_data_t; chk("R8 residue", d, 16'h0FFF);
    pulse_req(4);
  endtask

  task automatic t_suspend();
    logic [15:0] d;
    do_write(7'd17, 16'h00FF);
    addr_i = 7'd16;
    pulse_req(1);
    repeat (11) @(negedge clk_i);
    pulse_req(2);
    chk("R9 suspended", {8'h0, status_o}, 16'h00C0);
    addr_i = 7'd24; wdata_i = 16'h0000;
    pulse_req(0);
    pulse_req(1);
    repeat (3) @(negedge clk_i);
    chk("R11 status kept", {8'h0, status_o}, 16'h00C0);
    rd(7'd24, d); chk("R11 array kept", d, 16'hFFFF);
    pulse_req(3);
    wait_ready();
    chk("R9 resumed", {8'h0, status_o}, 16'h0080);
    rd(7'd17, d); chk("R9 word17", d, 16'hFFFF);
    rd(7'd23, d); chk("R9 word23", d, 16'hFFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_word_write();
    t_byte();
    t_vpp();
    t_retry();
    t_boot();
    t_erase();
    t_suspend();
    finish_run();
  end
endmodule